// File: doc/BRIEF.md
# I2C Register-File Target

This block is a two-wire serial target that answers on one fixed 7-bit address and holds a small byte array behind an index register. A bus controller addresses the target and may then send bytes. The first byte it sends after the address sets the index, and every later byte is stored at the index, which then advances. In the read direction the target returns the byte at the index, advances, and keeps returning bytes for as long as the controller acknowledges them.

The index is never cleared by the protocol. A read that is not preceded by an index write therefore carries on from wherever the last access left off. The SCL and SDA lines are brought in through two-flop synchronizers and are sampled on the system clock. The target pulls SDA low through a single drive-low output, which the board combines with the open-drain line. A separate local port reads the array directly without touching the bus.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target acknowledges only the address `DEV_ADDR` (default 7'h68) by holding SDA low through the ninth SCL pulse. For any other address it never pulls SDA low, and it writes nothing and leaves the index unchanged until the next START or STOP.
- R2: The first byte after a START or repeated START is taken MSB first as seven address bits followed by a direction bit, where 0 means write and 1 means read. The target keeps SDA released while receiving that byte.
- R3: In a write, the first byte after the address is acknowledged and its low log2(DEPTH) bits become the index. Nothing is stored by that byte.
- R4: Each later byte in a write is acknowledged, stored at the index, and the index then advances by one.
- R5: The index wraps from DEPTH-1 (63 by default) to 0 on both writes and reads.
- R6: In a read, the target drives the byte at the index MSB first and then advances the index. It sends the next byte while the controller acknowledges (SDA low on the ninth pulse). A not-acknowledge ends the read with SDA released.
- R7: The index persists across transactions. A read with no index write before it starts at the value left by the last access.
- R8: A repeated START in any state restarts address reception and leaves the index unchanged.
- R9: A STOP (SDA rising while SCL is high) returns the target to idle with SDA released. Bytes clocked without a following START receive no acknowledge and have no effect.
- R10: The drive-low output changes only while SCL is low.
- R11: Reset releases SDA and clears the index to 0. Array contents are kept.
- R12: The local read port returns array entry `lcl_addr` on `lcl_data` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| lcl_addr | input | log2(DEPTH) | Local read port address |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| lcl_data | output | 8 | Local read port data, registered |

## Verification
The hardest condition to reach is an index value that does not come from the bus write that just happened. Three cases produce it: a repeated START that cuts a write short, a read issued just after reset, and a transaction on a foreign address that must leave the index untouched. The stimulus reaches each one by first filling known entries through full writes and then parking the index with a write that sends only the index byte. It then interrupts or resets and issues a bare read, so the first returned byte shows where the index actually stands. Wrap-around is reached by setting the index to the last entry before a two-byte burst.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_s    = scl_ff[1];
  assign sda_s    = sda_ff[1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // line conditions: SDA edge while SCL held high over both samples
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data
);
  logic [7:0] mem [DEPTH];

  // no reset on the array so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int         DEPTH    = 64,
  parameter int         AW       = $clog2(DEPTH),
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [7:0]    rd_q,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_low
);
  tgt_state_e    state, after_ack;
  logic          ack_ph;
  logic          master_ack;
  logic [2:0]    cnt;
  logic [7:0]    shreg, tx;
  logic [7:0]    rx_byte;
  logic [AW-1:0] ptr_inc;

  assign rx_byte = {shreg[6:0], sda_s};
  assign ptr_inc = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      after_ack  <= ST_IDLE;
      ack_ph     <= 1'b0;
      master_ack <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      tx         <= '0;
      ptr        <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      sda_low    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_ev) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
      end else if (start_ev) begin
        state   <= ST_ADDR;
        cnt     <= '0;
        ack_ph  <= 1'b0;
        sda_low <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise) begin
              shreg <= rx_byte;
              cnt   <= cnt + 1'b1;
              if (cnt == 3'd7) begin
                ack_ph <= 1'b0;
                if (state == ST_ADDR) begin
                  if (shreg[6:0] == DEV_ADDR) begin
                    state     <= ST_ACK;
                    after_ack <= sda_s ? ST_RDATA : ST_PTR;
                  end else begin
                    state <= ST_IDLE;
                  end
                end else if (state == ST_PTR) begin
                  ptr       <= rx_byte[AW-1:0];
                  state     <= ST_ACK;
                  after_ack <= ST_WDATA;
                end else begin
                  wr_en     <= 1'b1;
                  wr_addr   <= ptr;
                  wr_data   <= rx_byte;
                  ptr       <= ptr_inc;
                  state     <= ST_ACK;
                  after_ack <= ST_WDATA;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!ack_ph) begin
                sda_low <= 1'b1;
                ack_ph  <= 1'b1;
              end else begin
                ack_ph <= 1'b0;
                cnt    <= '0;
                state  <= after_ack;
                if (after_ack == ST_RDATA) begin
                  tx      <= rd_q;
                  sda_low <= ~rd_q[7];
                end else begin
                  sda_low <= 1'b0;
                end
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_low <= 1'b0;
                ptr     <= ptr_inc;
                cnt     <= '0;
                state   <= ST_RACK;
              end else begin
                tx      <= {tx[6:0], 1'b0};
                sda_low <= ~tx[6];
                cnt     <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (master_ack) begin
                tx      <= rd_q;
                sda_low <= ~rd_q[7];
                state   <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10: output moves only after SCL was seen low
  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_low) |-> !$past(scl_s));

  // R9: idle never holds the line
  p_idle_release_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_low);

  // R9: a stop always lands in idle
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (state == ST_IDLE));

  // R2: line released while the address byte arrives
  p_addr_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR) |-> !sda_low);

  // R5: outside an index load the index only steps by one with wrap
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ptr) && $past(state) != ST_PTR) |->
      (ptr == (($past(ptr) == AW'(DEPTH - 1)) ? '0 : $past(ptr) + 1'b1)));
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter int         DEPTH    = 64,
  parameter logic [6:0] DEV_ADDR = 7'h68,
  localparam int        AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [AW-1:0] lcl_addr,
  output logic          sda_drive_low,
  output logic [7:0]    lcl_data
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [AW-1:0] ptr;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [7:0]    rd_q;

  i2c_line_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_tgt_fsm #(
    .DEPTH    (DEPTH),
    .AW       (AW),
    .DEV_ADDR (DEV_ADDR)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_q     (rd_q),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sda_low  (sda_drive_low)
  );

  i2c_tgt_regs #(
    .DEPTH (DEPTH),
    .AW    (AW)
  ) u_regs (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ra_addr (ptr),
    .ra_data (rd_q),
    .rb_addr (lcl_addr),
    .rb_data (lcl_data)
  );
endmodule

// File: tb/i2c_regfile_target_bench.sv
module i2c_regfile_target_bench;
  localparam int H = 10;
  localparam logic [7:0] AW_W = 8'hD0;
  localparam logic [7:0] AW_R = 8'hD1;
  // rows: {index byte, first data, second data}
  localparam logic [23:0] VEC [4] = '{24'h05A53C, 24'h3F817E, 24'h2000FF, 24'h4A5AC3};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [5:0] lcl_addr = '0;
  logic       sda_drive_low;
  logic [7:0] lcl_data;
  logic       sda_bus;

  int total = 0;
  int bad = 0;
  int r10_viol = 0;
  logic prev_low = 1'b0;
  logic [7:0] mdl [64];
  logic [5:0] mptr = '0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_drive_low;

  i2c_regfile_target u_i2c_regfile_target (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_m),
    .sda_i         (sda_bus),
    .lcl_addr      (lcl_addr),
    .sda_drive_low (sda_drive_low),
    .lcl_data      (lcl_data)
  );

  always @(posedge clk) begin
    if (!rst && (sda_drive_low !== prev_low) && scl_m) r10_viol++;
    prev_low = sda_drive_low;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; w(H);
    sda_m = 1'b0; w(H);
    scl_m = 1'b0; w(H);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; w(H);
    scl_m = 1'b1; w(H);
    sda_m = 1'b0; w(H);
    scl_m = 1'b0; w(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(H);
    scl_m = 1'b1; w(H);
    sda_m = 1'b1; w(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_bit);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(H);
      scl_m = 1'b1; w(H);
      scl_m = 1'b0;
    end
    w(H);
    sda_m = 1'b1; w(H);
    scl_m = 1'b1; w(H/2);
    ack_bit = sda_bus;
    w(H/2);
    scl_m = 1'b0; w(H);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H);
      scl_m = 1'b1; w(H/2);
      b[i] = sda_bus;
      w(H/2);
      scl_m = 1'b0;
    end
    w(H/2);
    sda_m = ~give_ack; w(H/2);
    scl_m = 1'b1; w(H);
    scl_m = 1'b0; w(H);
    sda_m = 1'b1;
  endtask

  task automatic set_index(input logic [7:0] p);
    logic a;
    bus_start();
    send_byte(AW_W, a); chk("R1 addr ack", a, 1'b0);
    send_byte(p, a);    chk("R3 index ack", a, 1'b0);
    bus_stop();
    mptr = p[5:0];
  endtask

  task automatic peek(input logic [5:0] ad, input logic [7:0] exp, input string req);
    lcl_addr = ad; w(2);
    chk(req, lcl_data, exp);
  endtask

  initial begin
    logic a;
    logic [7:0] rb;
    logic [5:0] p;
    w(5);
    chk("R11 reset release", sda_drive_low, 1'b0);
    rst = 1'b0; w(5);
    chk("R11 idle release", sda_drive_low, 1'b0);

    // table of write-then-read-back rows
    for (int k = 0; k < 4; k++) begin
      p = VEC[k][21:16];
      bus_start();
      send_byte(AW_W, a);        chk("R1 addr ack", a, 1'b0);
      send_byte(VEC[k][23:16], a); chk("R3 index ack", a, 1'b0);
      send_byte(VEC[k][15:8], a);  chk("R4 data ack", a, 1'b0);
      send_byte(VEC[k][7:0], a);   chk("R4 data ack", a, 1'b0);
      bus_stop();
      chk("R9 released after stop", sda_drive_low, 1'b0);
      mdl[p] = VEC[k][15:8];
      mdl[p + 6'd1] = VEC[k][7:0];
      peek(p, VEC[k][15:8], "R12 local read");
      peek(p + 6'd1, VEC[k][7:0], "R5 R4 next entry");
      bus_start();
      send_byte(AW_W, a);
      send_byte(VEC[k][23:16], a);
      bus_rstart();
      send_byte(AW_R, a);        chk("R2 read addr ack", a, 1'b0);
      recv_byte(1'b1, rb);       chk("R6 first read byte", rb, VEC[k][15:8]);
      recv_byte(1'b0, rb);       chk("R6 R5 second read byte", rb, VEC[k][7:0]);
      chk("R6 released after nack", sda_drive_low, 1'b0);
      bus_stop();
      mptr = p + 6'd2;
    end

    // R7: index persists across transactions
    bus_start();
    send_byte(AW_W, a); send_byte(8'h0C, a);
    send_byte(8'h96, a); send_byte(8'h69, a); send_byte(8'h12, a);
    chk("R4 third byte ack", a, 1'b0);
    bus_stop();
    mdl[12] = 8'h96; mdl[13] = 8'h69; mdl[14] = 8'h12;
    set_index(8'h0C);
    bus_start();
    send_byte(AW_R, a);
    recv_byte(1'b1, rb); chk("R7 bare read start", rb, 8'h96);
    recv_byte(1'b0, rb); chk("R6 burst continues", rb, 8'h69);
    bus_stop();
    bus_start();
    send_byte(AW_R, a);
    recv_byte(1'b0, rb); chk("R7 read resumes", rb, 8'h12);
    bus_stop();

    // R1: foreign addresses
    set_index(8'h05);
    bus_start();
    send_byte(8'hA0, a); chk("R1 foreign nack", a, 1'b1);
    send_byte(8'h05, a); chk("R1 ignored byte", a, 1'b1);
    send_byte(8'h77, a); chk("R1 ignored byte", a, 1'b1);
    bus_stop();
    bus_start();
    send_byte(8'hD2, a); chk("R1 near address nack", a, 1'b1);
    bus_stop();
    peek(6'h05, 8'hA5, "R1 entry untouched");
    bus_start();
    send_byte(AW_R, a);
    recv_byte(1'b0, rb); chk("R1 index untouched", rb, 8'hA5);
    bus_stop();

    // R9: bytes without a START after STOP are ignored
    set_index(8'h05);
    send_byte(AW_W, a); chk("R9 stray byte nack", a, 1'b1);
    send_byte(8'h22, a); chk("R9 stray byte nack", a, 1'b1);
    bus_stop();
    bus_start();
    send_byte(AW_R, a);
    recv_byte(1'b0, rb); chk("R9 index untouched", rb, 8'hA5);
    bus_stop();

    // R8: repeated start mid-write keeps index
    bus_start();
    send_byte(AW_W, a); send_byte(8'h10, a);
    send_byte(8'h44, a); send_byte(8'h55, a);
    bus_stop();
    bus_start();
    send_byte(AW_W, a); send_byte(8'h10, a); send_byte(8'h44, a);
    bus_rstart();
    send_byte(AW_R, a); chk("R8 ack after restart", a, 1'b0);
    recv_byte(1'b0, rb); chk("R8 index kept", rb, 8'h55);
    bus_stop();

    // R11: reset clears the index, keeps contents
    set_index(8'h20);
    rst = 1'b1; w(4);
    chk("R11 release in reset", sda_drive_low, 1'b0);
    rst = 1'b0; w(4);
    bus_start();
    send_byte(AW_R, a);
    recv_byte(1'b0, rb); chk("R11 index zero", rb, mdl[0]);
    bus_stop();

    chk("R10 drive only while SCL low", r10_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule